// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block adds two 20-bit operands and a carry-in and returns a 20-bit sum and a carry-out, all in combinational logic. The operand bits fall into five groups whose sizes grow by one bit at each step: 2, 3, 4, 5 and 6 bits. The lowest group has one ripple chain fed by the external carry-in. Every higher group runs two ripple chains side by side. One chain assumes a group carry-in of 0 and the other assumes 1. The real carry into the group then picks one result through a multiplexer.

Because each group is one bit longer than the group below it, its two precomputed results are ready at about the time the select carry arrives from below. The longest path therefore grows with the square root of the operand width rather than linearly. The block sits in a datapath wherever a single-cycle add of this width is needed.

The group sizes are set by two parameters: the size of the first group and the number of groups. The operand width is derived from them. The defaults give the 20-bit layout.

Top module: `sqrt_csel_adder`

## Requirements
- R1: For each bit the setup stage forms generate = a AND b and propagate = a XOR b, so no bit is ever both generate and propagate.
- R2: In every group above the lowest, the chain that assumes carry-in 1 gives a result one greater than the chain that assumes carry-in 0, taking the group sum and carry-out together as one number.
- R3: In every group above the lowest, the real carry into the group selects the sum bits and the carry-out. A carry of 0 takes the carry-in-0 chain and a carry of 1 takes the carry-in-1 chain.
- R4: The groups cover bits 0-1, 2-4, 5-8, 9-13 and 14-19. A carry produced at the top bit of any group reaches the lowest bit of the next group.
- R5: The selected carry-out of each group is the select carry of the next group. It equals bit LO of (a[LO-1:0] + b[LO-1:0] + cin), where LO is the lowest bit of the receiving group.
- R6: sum_o equals (a_i + b_i + cin_i) mod 2^20, and cout_o equals bit 20 of that addition, for any operands.
- R7: With every bit propagating (a_i XOR b_i all ones) and cin_i = 1, sum_o is 0 and cout_o is 1.
- R8: All-zero operands with cin_i = 0 give sum_o = 0 and cout_o = 0. All-ones operands with cin_i = 1 give sum_o = 0xFFFFF and cout_o = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 20 | First operand |
| b_i | input | 20 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 20 | Sum, modulo 2^20 |
| cout_o | output | 1 | Carry out of bit 19 |

## Verification
The assertions are immediate checks inside combinational blocks. They take for granted that the operands and carry-in are two-state values that stay steady while the logic settles, so they never see an input in the middle of a change.

The bench changes inputs only at the falling clock edge, in one step, and never drives X or Z. It samples a quarter period later. Directed vectors place a carry at each group boundary and cover the all-propagate, all-zero and all-ones corners. Random vectors from a fixed seed cover the general sum.

// File: rtl/csel_pkg.sv
package csel_pkg;

    // Lowest bit index of group k when the first group holds 'first' bits
    // and each later group is one bit wider than the one before it.
    function automatic int grp_lo(input int k, input int first);
        return k * first + (k * (k - 1)) / 2;
    endfunction

    // Width of group k.
    function automatic int grp_size(input int k, input int first);
        return first + k;
    endfunction

endpackage

// File: rtl/csel_pg.sv
module csel_pg #(
    parameter int W = 20
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] gen_o,
    output logic [W-1:0] prop_o
);
    logic [W-1:0] gen_d;
    logic [W-1:0] prop_d;

    always_comb begin
        gen_d  = a_i & b_i;
        prop_d = a_i ^ b_i;
    end

    assign gen_o  = gen_d;
    assign prop_o = prop_d;

    always_comb begin
        AST_PG_EXCLUSIVE: assert ((gen_o & prop_o) == '0); // R1
        AST_PG_COVER: assert ((gen_o | prop_o) == (a_i | b_i)); // R1
    end
endmodule

// File: rtl/csel_ripple.sv
module csel_ripple #(
    parameter int SZ = 4
) (
    input  logic [SZ-1:0] gen_i,
    input  logic [SZ-1:0] prop_i,
    input  logic          cin_i,
    output logic [SZ-1:0] sum_o,
    output logic          cout_o
);
    logic [SZ:0]   carry_d;
    logic [SZ-1:0] sum_d;

    always_comb begin
        carry_d[0] = cin_i;
        for (int i = 0; i < SZ; i++) begin
            sum_d[i]       = prop_i[i] ^ carry_d[i];
            carry_d[i + 1] = gen_i[i] | (prop_i[i] & carry_d[i]);
        end
    end

    assign sum_o  = sum_d;
    assign cout_o = carry_d[SZ];
endmodule

// File: rtl/csel_group.sv
module csel_group #(
    parameter int SZ = 4
) (
    input  logic [SZ-1:0] gen_i,
    input  logic [SZ-1:0] prop_i,
    input  logic          sel_i,
    output logic [SZ-1:0] sum_o,
    output logic          cout_o
);
    logic [SZ-1:0] sum0;
    logic [SZ-1:0] sum1;
    logic          co0;
    logic          co1;

    csel_ripple #(.SZ(SZ)) u_chain0 (
        .gen_i  (gen_i),
        .prop_i (prop_i),
        .cin_i  (1'b0),
        .sum_o  (sum0),
        .cout_o (co0)
    );

    csel_ripple #(.SZ(SZ)) u_chain1 (
        .gen_i  (gen_i),
        .prop_i (prop_i),
        .cin_i  (1'b1),
        .sum_o  (sum1),
        .cout_o (co1)
    );

    logic [SZ-1:0] sum_d;
    logic          cout_d;

    always_comb begin
        if (sel_i) begin
            sum_d  = sum1;
            cout_d = co1;
        end else begin
            sum_d  = sum0;
            cout_d = co0;
        end
    end

    assign sum_o  = sum_d;
    assign cout_o = cout_d;

    always_comb begin
        AST_CHAINS_OFF_BY_ONE: assert ({co1, sum1} == ({co0, sum0} + {{SZ{1'b0}}, 1'b1})); // R2
    end
endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder #(
    parameter int FIRST_GROUP = 2,
    parameter int NUM_GROUPS  = 5,
    localparam int WIDTH = csel_pkg::grp_lo(NUM_GROUPS, FIRST_GROUP)
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    logic [WIDTH-1:0]    gen;
    logic [WIDTH-1:0]    prop;
    logic [NUM_GROUPS:0] grp_carry;

    csel_pg #(.W(WIDTH)) u_pg (
        .a_i    (a_i),
        .b_i    (b_i),
        .gen_o  (gen),
        .prop_o (prop)
    );

    assign grp_carry[0] = cin_i;

    for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_grp
        localparam int LO = csel_pkg::grp_lo(k, FIRST_GROUP);
        localparam int SZ = csel_pkg::grp_size(k, FIRST_GROUP);

        if (k == 0) begin : g_base
            csel_ripple #(.SZ(SZ)) u_base (
                .gen_i  (gen[LO +: SZ]),
                .prop_i (prop[LO +: SZ]),
                .cin_i  (grp_carry[k]),
                .sum_o  (sum_o[LO +: SZ]),
                .cout_o (grp_carry[k + 1])
            );
        end else begin : g_sel
            csel_group #(.SZ(SZ)) u_grp (
                .gen_i  (gen[LO +: SZ]),
                .prop_i (prop[LO +: SZ]),
                .sel_i  (grp_carry[k]),
                .sum_o  (sum_o[LO +: SZ]),
                .cout_o (grp_carry[k + 1])
            );

            logic [LO:0] low_ref;
            assign low_ref = {1'b0, a_i[LO-1:0]} + {1'b0, b_i[LO-1:0]}
                           + {{LO{1'b0}}, cin_i};

            always_comb begin
                AST_SELECT_CARRY: assert (low_ref == {grp_carry[k], sum_o[LO-1:0]}); // R5
            end
        end
    end

    assign cout_o = grp_carry[NUM_GROUPS];

    logic [WIDTH:0] full_ref;
    assign full_ref = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

    always_comb begin
        AST_FULL_SUM: assert (full_ref == {cout_o, sum_o}); // R6
    end
endmodule

// File: tb/sqrt_csel_adder_test.sv
module sqrt_csel_adder_test;
    localparam int W = 20;

    logic         clk = 1'b0;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         cin;
    logic [W-1:0] sum;
    logic         cout;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    sqrt_csel_adder uut (
        .a_i    (a),
        .b_i    (b),
        .cin_i  (cin),
        .sum_o  (sum),
        .cout_o (cout)
    );

    function automatic logic [W:0] model_add(input logic [W-1:0] x,
                                             input logic [W-1:0] y,
                                             input logic c);
        logic [W:0] r;
        r = 0;
        r = r + x;
        r = r + y;
        r = r + c;
        return r;
    endfunction

    task automatic run_vec(input logic [W-1:0] x, input logic [W-1:0] y,
                           input logic c, input string req);
        logic [W:0] exp;
        @(negedge clk);
        a   = x;
        b   = y;
        cin = c;
        exp = model_add(x, y, c);
        #5;
        n_tests++;
        if ({cout, sum} !== exp) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h cin=%b got cout=%b sum=%h expected cout=%b sum=%h",
                     req, x, y, c, cout, sum, exp[W], exp[W-1:0]);
        end
    endtask

    initial begin
        a   = '0;
        b   = '0;
        cin = 1'b0;
        void'($urandom(32'h5eed_1234));

        // R8: all zeros
        run_vec(20'h00000, 20'h00000, 1'b0, "R8 zeros");
        // R8: all ones with carry-in
        run_vec(20'hFFFFF, 20'hFFFFF, 1'b1, "R8 ones");
        run_vec(20'hFFFFF, 20'hFFFFF, 1'b0, "R8 ones cin0");
        // R7: all-propagate with carry-in 1
        run_vec(20'hFFFFF, 20'h00000, 1'b1, "R7 propagate");
        run_vec(20'hA5A5A, 20'h5A5A5, 1'b1, "R7 propagate mixed");
        run_vec(20'h0F0F0, 20'hF0F0F, 1'b0, "R7 propagate cin0");
        // R1: generate-only and propagate-only bit patterns
        run_vec(20'h12345, 20'h12345, 1'b0, "R1 generate only");
        run_vec(20'hCCCCC, 20'h33333, 1'b0, "R1 propagate only");
        // R4: carry out of the top bit of each group into the next
        run_vec(20'h00003, 20'h00001, 1'b0, "R4 bit1 to bit2");
        run_vec(20'h0001F, 20'h00000, 1'b1, "R4 bit4 to bit5");
        run_vec(20'h00100, 20'h00100, 1'b0, "R4 bit8 to bit9");
        run_vec(20'h02000, 20'h02000, 1'b0, "R4 bit13 to bit14");
        run_vec(20'h80000, 20'h80000, 1'b0, "R4 bit19 to cout");
        // R3: same upper operand bits, select carry 0 versus 1 into each group
        for (int lo_i = 0; lo_i < 5; lo_i++) begin
            int lo;
            logic [W-1:0] m;
            lo = lo_i * 2 + (lo_i * (lo_i - 1)) / 2;
            if (lo == 0) continue;
            m = (20'h1 << lo) - 20'h1;
            run_vec(20'h55555 & ~m, 20'h0AAAA & ~m, 1'b0, "R3 select 0");
            run_vec((20'h55555 & ~m) | m, 20'h0AAAA & ~m, 1'b1, "R3 select 1");
        end
        // R5: carry ripples through several groups before selecting
        run_vec(20'h001FF, 20'h00001, 1'b0, "R5 chained select");
        run_vec(20'h03FFE, 20'h00001, 1'b1, "R5 chained select cin");
        // R2 and R6: random vectors
        for (int i = 0; i < 2000; i++) begin
            logic [W-1:0] x;
            logic [W-1:0] y;
            x = W'($urandom);
            y = W'($urandom);
            run_vec(x, y, 1'($urandom), "R6 random");
        end
        for (int i = 0; i < 200; i++) begin
            logic [W-1:0] x;
            x = W'($urandom);
            run_vec(x, ~x, 1'($urandom), "R2 random propagate");
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule